// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns an interrupt request into the set of agents that should receive it. A request carries a destination byte, a physical/logical selector, a two-bit shorthand code, a three-bit delivery mode, a vector and the level and trigger bits. The resolver walks a table of per-agent settings, one slot per clock. Each slot holds a populated flag, an 8-bit agent ID, an 8-bit logical address and a 4-bit addressing model. The walk builds a target bitmask. A delivery stage then turns that mask into the final receiver set and an action code.

The agent table is loaded through a single write port. Two per-agent side records can be read back through a combinational read port. The first is an arbitration ID, filled by INIT de-assert requests. The second is a startup vector, filled by startup requests. A request is accepted while the block is idle. The result appears together with a one-cycle `done` strobe once the walk has covered every slot. Actual signalling of processors and priority arbitration belong to the surrounding logic.

Top module: `intr_dest_resolver`

## Requirements
- R1: In physical addressing (req_logical = 0, shorthand 0), destination 0xFF selects every populated slot.
- R2: In physical addressing with any other destination, only the lowest-numbered populated slot whose ID equals the destination is selected. If no populated slot has that ID, nothing is selected.
- R3: In logical addressing, a populated slot whose model field is 4'hF (flat) is selected when the bitwise AND of the destination and its logical address is nonzero.
- R4: In logical addressing, a populated slot whose model field is 4'h0 (cluster) is selected when the upper nibbles of the destination and its logical address are equal and their lower nibbles have at least one set bit in common. A slot with any other model value is never selected in logical addressing.
- R5: The shorthand code works as follows. 0 uses the destination fields. 1 selects only slot req_src. 2 selects every populated slot. 3 selects every populated slot except req_src.
- R6: A slot whose populated flag is 0 never appears in any output mask, including for broadcast and shorthand requests.
- R7: The delivery modes map to output action codes. Fixed (0) gives action 1. SMI (2) gives action 3. NMI (4) gives action 4. INIT (5) gives action 5. Startup (6) gives action 6. Each of these outputs the full selected mask. External interrupt (7) and the reserved code 3 give action 0 with an empty mask.
- R8: Lowest-priority delivery (mode 1) gives action 2. Its mask holds only the lowest-numbered selected slot, low_valid is 1 and low_slot is that slot. When nothing is selected, the mask is empty and low_valid is 0.
- R9: INIT with req_level = 0 and req_trigger = 1 gives action 7 and an empty mask. It copies each selected slot's ID into that slot's arbitration ID. If a configuration write hits the same slot at the completing edge, the copy takes the ID held before that write.
- R10: A startup request stores req_vector as the startup vector of every selected slot. The startup vectors of unselected slots are unchanged.
- R11: An accepted request keeps busy high and done low for NUM_AGENTS+1 cycles. done then pulses high for exactly one cycle. Requests presented while busy is high are ignored.
- R12: After reset, done and busy are 0, the output mask is empty, the table holds no populated slot, and every arbitration ID and startup vector reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the agent table |
| cfg_slot | input | SLOT_W | Slot index to write |
| cfg_present | input | 1 | Populated flag for the slot |
| cfg_id | input | 8 | Agent ID |
| cfg_ldest | input | 8 | Logical address |
| cfg_model | input | 4 | Logical addressing model (F flat, 0 cluster) |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_short | input | 2 | Destination shorthand code |
| req_mode | input | 3 | Delivery mode |
| req_vector | input | 8 | Interrupt or startup vector |
| req_level | input | 1 | Level bit |
| req_trigger | input | 1 | Trigger bit |
| req_src | input | SLOT_W | Slot of the requesting agent |
| rd_slot | input | SLOT_W | Slot for the side-record read |
| rd_arb_id | output | 8 | Arbitration ID of rd_slot |
| rd_start_vec | output | 8 | Startup vector of rd_slot |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion strobe |
| tgt_mask | output | NUM_AGENTS | Receiver bitmask |
| tgt_action | output | 3 | Action code |
| tgt_vector | output | 8 | Vector of the completed request |
| low_valid | output | 1 | Lowest-priority receiver found |
| low_slot | output | SLOT_W | Lowest-priority receiver slot |

## Verification
Two events can share one clock edge. One is the completion edge of an INIT de-assert, which copies IDs into arbitration IDs. The other is a table write that replaces the ID of one of the selected slots. The bench provokes this by timing a configuration write to land exactly on the completing edge. It then reads back the arbitration IDs and expects the pre-write ID in the written slot, while its behavioural model applies the new ID only afterwards. A second overlap comes from a request injected while a walk is running. The bench judges it by requiring that the result and the single done pulse match the first request alone.

// File: rtl/resolver_pkg.sv
package resolver_pkg;

    localparam logic [7:0] DEST_BCAST    = 8'hFF;
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    typedef struct packed {
        logic       present;
        logic [7:0] id;
        logic [7:0] ldest;
        logic [3:0] model;
    } agent_cfg_t;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_FIXED  = 3'd1,
        ACT_LOWEST = 3'd2,
        ACT_SMI    = 3'd3,
        ACT_NMI    = 3'd4,
        ACT_INIT   = 3'd5,
        ACT_START  = 3'd6,
        ACT_ARB    = 3'd7
    } act_e;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } sh_e;

    typedef struct packed {
        logic [7:0] dest;
        logic       logical;
        sh_e        sh;
        dmode_e     mode;
        logic [7:0] vector;
        logic       level;
        logic       trigger;
    } req_t;

    function automatic logic logical_hit(logic [7:0] dest, agent_cfg_t a);
        logic hit;
        hit = 1'b0;
        if (a.model == MODEL_FLAT)
            hit = |(dest & a.ldest);
        else if (a.model == MODEL_CLUSTER)
            hit = (dest[7:4] == a.ldest[7:4]) && (|(dest[3:0] & a.ldest[3:0]));
        return hit;
    endfunction

    function automatic logic is_arb_sync(req_t r);
        return (r.mode == DM_INIT) && !r.level && r.trigger;
    endfunction

endpackage

// File: rtl/resolver_table.sv
module resolver_table
    import resolver_pkg::*;
#(
    parameter int NUM_AGENTS = 255,
    parameter int SLOT_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  agent_cfg_t                   wr_cfg,
    output agent_cfg_t [NUM_AGENTS-1:0]  cfg_q,
    input  logic                         upd_arb,
    input  logic                         upd_start,
    input  logic [NUM_AGENTS-1:0]        upd_mask,
    input  logic [7:0]                   upd_vec,
    input  logic [SLOT_W-1:0]            rd_slot,
    output logic [7:0]                   rd_arb,
    output logic [7:0]                   rd_vec
);

    logic [7:0] arb_q [NUM_AGENTS];
    logic [7:0] vec_q [NUM_AGENTS];

    // One slot per generate step; side records capture the old ID on a same-edge write.
    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
                arb_q[g] <= '0;
                vec_q[g] <= '0;
            end else begin
                if (wr_en && wr_slot == SLOT_W'(g))
                    cfg_q[g] <= wr_cfg;
                if (upd_arb && upd_mask[g])
                    arb_q[g] <= cfg_q[g].id;
                if (upd_start && upd_mask[g])
                    vec_q[g] <= upd_vec;
            end
        end
    end

    always_comb begin
        rd_arb = '0;
        rd_vec = '0;
        if (int'(rd_slot) < NUM_AGENTS) begin
            rd_arb = arb_q[rd_slot];
            rd_vec = vec_q[rd_slot];
        end
    end

endmodule

// File: rtl/resolver_scan.sv
module resolver_scan
    import resolver_pkg::*;
#(
    parameter int NUM_AGENTS = 255,
    parameter int SLOT_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  req_t                         req_in,
    input  logic [SLOT_W-1:0]            src_in,
    input  agent_cfg_t [NUM_AGENTS-1:0]  cfg,
    output logic                         busy,
    output logic                         fin,
    output req_t                         req_q,
    output logic [NUM_AGENTS-1:0]        mask_q,
    output logic                         first_found,
    output logic [SLOT_W-1:0]            first_idx
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_AGENTS - 1);

    logic [SLOT_W-1:0] idx_q;
    logic [SLOT_W-1:0] src_q;
    agent_cfg_t        cur;
    logic              hit;

    assign cur = cfg[idx_q];

    always_comb begin
        hit = 1'b0;
        unique case (req_q.sh)
            SH_DEST: begin
                if (!req_q.logical)
                    hit = cur.present &&
                          (req_q.dest == DEST_BCAST ||
                           (cur.id == req_q.dest && !first_found));
                else
                    hit = cur.present && logical_hit(req_q.dest, cur);
            end
            SH_SELF:   hit = cur.present && (idx_q == src_q);
            SH_ALL:    hit = cur.present;
            SH_OTHERS: hit = cur.present && (idx_q != src_q);
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            fin         <= 1'b0;
            idx_q       <= '0;
            src_q       <= '0;
            req_q       <= '0;
            mask_q      <= '0;
            first_found <= 1'b0;
            first_idx   <= '0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                busy        <= 1'b1;
                idx_q       <= '0;
                src_q       <= src_in;
                req_q       <= req_in;
                mask_q      <= '0;
                first_found <= 1'b0;
                first_idx   <= '0;
            end else if (busy) begin
                mask_q[idx_q] <= hit;
                if (hit && !first_found) begin
                    first_found <= 1'b1;
                    first_idx   <= idx_q;
                end
                if (idx_q == LAST) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    idx_q <= idx_q + SLOT_W'(1);
                end
            end
        end
    end

    // R11: the walk advances one slot per clock
    a_r11_step: assert property (@(posedge clk) disable iff (rst)
        busy && idx_q != LAST |=> busy && idx_q == $past(idx_q) + SLOT_W'(1));

    // R11: completion only follows the last slot
    a_r11_fin_last: assert property (@(posedge clk) disable iff (rst)
        busy && idx_q == LAST |=> fin && !busy);

    // R6: an unpopulated slot leaves its mask bit clear
    a_r6_unpop: assert property (@(posedge clk) disable iff (rst)
        busy && !cur.present |=> !mask_q[$past(idx_q)]);

    // R2: physical unicast never selects more than one slot
    a_r2_single: assert property (@(posedge clk) disable iff (rst)
        fin && req_q.sh == SH_DEST && !req_q.logical && req_q.dest != DEST_BCAST
        |-> $onehot0(mask_q));

endmodule

// File: rtl/resolver_deliver.sv
module resolver_deliver
    import resolver_pkg::*;
#(
    parameter int NUM_AGENTS = 255,
    parameter int SLOT_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fin,
    input  dmode_e                 mode,
    input  logic                   level,
    input  logic                   trigger,
    input  logic [7:0]             vector,
    input  logic [NUM_AGENTS-1:0]  mask,
    input  logic                   first_found,
    input  logic [SLOT_W-1:0]      first_idx,
    output logic                   done,
    output logic [NUM_AGENTS-1:0]  out_mask,
    output act_e                   out_act,
    output logic [7:0]             out_vec,
    output logic                   low_valid,
    output logic [SLOT_W-1:0]      low_idx,
    output logic                   upd_arb,
    output logic                   upd_start
);

    logic [NUM_AGENTS-1:0] low_onehot;
    logic [NUM_AGENTS-1:0] nxt_mask;
    act_e                  nxt_act;

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_low
        assign low_onehot[g] = first_found && (first_idx == SLOT_W'(g));
    end

    always_comb begin
        nxt_act  = ACT_NONE;
        nxt_mask = '0;
        unique case (mode)
            DM_FIXED:  begin nxt_act = ACT_FIXED;  nxt_mask = mask;       end
            DM_LOWEST: begin nxt_act = ACT_LOWEST; nxt_mask = low_onehot; end
            DM_SMI:    begin nxt_act = ACT_SMI;    nxt_mask = mask;       end
            DM_NMI:    begin nxt_act = ACT_NMI;    nxt_mask = mask;       end
            DM_INIT: begin
                if (!level && trigger) begin
                    nxt_act = ACT_ARB;
                end else begin
                    nxt_act  = ACT_INIT;
                    nxt_mask = mask;
                end
            end
            DM_START:  begin nxt_act = ACT_START;  nxt_mask = mask;       end
            default:   begin nxt_act = ACT_NONE;   nxt_mask = '0;         end
        endcase
    end

    assign upd_arb   = fin && (nxt_act == ACT_ARB);
    assign upd_start = fin && (nxt_act == ACT_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            out_mask  <= '0;
            out_act   <= ACT_NONE;
            out_vec   <= '0;
            low_valid <= 1'b0;
            low_idx   <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                out_mask  <= nxt_mask;
                out_act   <= nxt_act;
                out_vec   <= vector;
                low_valid <= (mode == DM_LOWEST) && first_found;
                low_idx   <= ((mode == DM_LOWEST) && first_found) ? first_idx : '0;
            end
        end
    end

    // R11: completion strobe lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: lowest-priority result names at most one receiver
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        done && out_act == ACT_LOWEST |-> $onehot0(out_mask));

    // R8: the reported slot is the one set in the mask
    a_r8_low_bit: assert property (@(posedge clk) disable iff (rst)
        done && low_valid |-> out_mask[low_idx] && out_act == ACT_LOWEST);

    // R9: de-assert delivers to nobody
    a_r9_silent: assert property (@(posedge clk) disable iff (rst)
        done && out_act == ACT_ARB |-> out_mask == '0);

    // R7: undelivered modes leave the mask empty
    a_r7_none_empty: assert property (@(posedge clk) disable iff (rst)
        done && out_act == ACT_NONE |-> out_mask == '0);

endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
    import resolver_pkg::*;
#(
    parameter int NUM_AGENTS = 255,
    parameter int SLOT_W     = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [SLOT_W-1:0]      cfg_slot,
    input  logic                   cfg_present,
    input  logic [7:0]             cfg_id,
    input  logic [7:0]             cfg_ldest,
    input  logic [3:0]             cfg_model,
    input  logic                   req_valid,
    input  logic [7:0]             req_dest,
    input  logic                   req_logical,
    input  logic [1:0]             req_short,
    input  logic [2:0]             req_mode,
    input  logic [7:0]             req_vector,
    input  logic                   req_level,
    input  logic                   req_trigger,
    input  logic [SLOT_W-1:0]      req_src,
    input  logic [SLOT_W-1:0]      rd_slot,
    output logic [7:0]             rd_arb_id,
    output logic [7:0]             rd_start_vec,
    output logic                   busy,
    output logic                   done,
    output logic [NUM_AGENTS-1:0]  tgt_mask,
    output logic [2:0]             tgt_action,
    output logic [7:0]             tgt_vector,
    output logic                   low_valid,
    output logic [SLOT_W-1:0]      low_slot
);

    agent_cfg_t                  wr_cfg;
    agent_cfg_t [NUM_AGENTS-1:0] cfg_all;
    req_t                        req_in;
    req_t                        req_q;
    logic                        scan_busy;
    logic                        scan_fin;
    logic [NUM_AGENTS-1:0]       scan_mask;
    logic                        first_found;
    logic [SLOT_W-1:0]           first_idx;
    logic                        upd_arb;
    logic                        upd_start;
    act_e                        act;

    assign wr_cfg = '{present: cfg_present, id: cfg_id, ldest: cfg_ldest, model: cfg_model};
    assign req_in = '{dest: req_dest, logical: req_logical, sh: sh_e'(req_short),
                      mode: dmode_e'(req_mode), vector: req_vector,
                      level: req_level, trigger: req_trigger};

    // The completion cycle counts as busy so the result stage is never overrun.
    assign busy = scan_busy || scan_fin;

    resolver_table #(.NUM_AGENTS(NUM_AGENTS), .SLOT_W(SLOT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_slot   (cfg_slot),
        .wr_cfg    (wr_cfg),
        .cfg_q     (cfg_all),
        .upd_arb   (upd_arb),
        .upd_start (upd_start),
        .upd_mask  (scan_mask),
        .upd_vec   (req_q.vector),
        .rd_slot   (rd_slot),
        .rd_arb    (rd_arb_id),
        .rd_vec    (rd_start_vec)
    );

    resolver_scan #(.NUM_AGENTS(NUM_AGENTS), .SLOT_W(SLOT_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .start       (req_valid && !busy),
        .req_in      (req_in),
        .src_in      (req_src),
        .cfg         (cfg_all),
        .busy        (scan_busy),
        .fin         (scan_fin),
        .req_q       (req_q),
        .mask_q      (scan_mask),
        .first_found (first_found),
        .first_idx   (first_idx)
    );

    resolver_deliver #(.NUM_AGENTS(NUM_AGENTS), .SLOT_W(SLOT_W)) u_deliver (
        .clk         (clk),
        .rst         (rst),
        .fin         (scan_fin),
        .mode        (req_q.mode),
        .level       (req_q.level),
        .trigger     (req_q.trigger),
        .vector      (req_q.vector),
        .mask        (scan_mask),
        .first_found (first_found),
        .first_idx   (first_idx),
        .done        (done),
        .out_mask    (tgt_mask),
        .out_act     (act),
        .out_vec     (tgt_vector),
        .low_valid   (low_valid),
        .low_idx     (low_slot),
        .upd_arb     (upd_arb),
        .upd_start   (upd_start)
    );

    assign tgt_action = act;

    // R11: a request arriving mid-walk does not restart it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        scan_busy && req_valid |=> scan_busy || scan_fin);

endmodule

// File: tb/intr_dest_resolver_test.sv
`timescale 1ns/1ps
module intr_dest_resolver_test;

    localparam int N  = 20;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_slot = '0;
    logic          cfg_present = 1'b0;
    logic [7:0]    cfg_id = '0, cfg_ldest = '0;
    logic [3:0]    cfg_model = '0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_dest = '0;
    logic          req_logical = 1'b0;
    logic [1:0]    req_short = '0;
    logic [2:0]    req_mode = '0;
    logic [7:0]    req_vector = '0;
    logic          req_level = 1'b0, req_trigger = 1'b0;
    logic [IW-1:0] req_src = '0;
    logic [IW-1:0] rd_slot = '0;
    logic [7:0]    rd_arb_id, rd_start_vec;
    logic          busy, done, low_valid;
    logic [N-1:0]  tgt_mask;
    logic [2:0]    tgt_action;
    logic [7:0]    tgt_vector;
    logic [IW-1:0] low_slot;

    intr_dest_resolver #(.NUM_AGENTS(N), .SLOT_W(IW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_present(cfg_present), .cfg_id(cfg_id), .cfg_ldest(cfg_ldest),
        .cfg_model(cfg_model), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_short(req_short), .req_mode(req_mode),
        .req_vector(req_vector), .req_level(req_level), .req_trigger(req_trigger),
        .req_src(req_src), .rd_slot(rd_slot), .rd_arb_id(rd_arb_id),
        .rd_start_vec(rd_start_vec), .busy(busy), .done(done), .tgt_mask(tgt_mask),
        .tgt_action(tgt_action), .tgt_vector(tgt_vector), .low_valid(low_valid),
        .low_slot(low_slot)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // behavioural model of the table
    bit       m_pres [N];
    bit [7:0] m_id   [N];
    bit [7:0] m_ld   [N];
    bit [3:0] m_mdl  [N];
    bit [7:0] m_arb  [N];
    bit [7:0] m_vec  [N];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    task automatic cfg_write(input int slot, input bit pres, input bit [7:0] id,
                             input bit [7:0] ld, input bit [3:0] mdl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = IW'(slot); cfg_present = pres;
        cfg_id = id; cfg_ldest = ld; cfg_model = mdl;
        @(negedge clk);
        cfg_we = 1'b0;
        m_pres[slot] = pres; m_id[slot] = id; m_ld[slot] = ld; m_mdl[slot] = mdl;
    endtask

    task automatic check_tables(input string rq);
        bit ok = 1'b1;
        logic [63:0] g = 0, e = 0;
        for (int i = 0; i < N; i++) begin
            rd_slot = IW'(i);
            #0.5;
            if (ok && (rd_arb_id !== m_arb[i] || rd_start_vec !== m_vec[i])) begin
                ok = 1'b0;
                g = {32'(i), 16'(rd_arb_id), 16'(rd_start_vec)};
                e = {32'(i), 16'(m_arb[i]), 16'(m_vec[i])};
            end
        end
        chk(ok, rq, "side records {slot,arb,vec}", g, e);
    endtask

    // Runs one request; optional same-edge table write and mid-walk injection.
    task automatic run_req(input bit [7:0] d, input bit lg, input bit [1:0] sh,
                           input bit [2:0] md, input bit [7:0] v, input bit lv,
                           input bit tr, input int src, input bit cw,
                           input int cw_slot, input bit [7:0] cw_id,
                           input bit inject, input string rq);
        bit            sel [N];
        bit            found = 1'b0;
        int            lowest = -1;
        logic [N-1:0]  exp_mask = '0;
        logic [2:0]    exp_act;
        bit            early = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel[i] = 1'b0;
            case (sh)
                2'd0: begin
                    if (!lg) begin
                        if (d == 8'hFF) sel[i] = m_pres[i];
                        else if (!found && m_pres[i] && m_id[i] == d) begin
                            sel[i] = 1'b1; found = 1'b1;
                        end
                    end else if (m_pres[i]) begin
                        if (m_mdl[i] == 4'hF) sel[i] = (d & m_ld[i]) != 0;
                        else if (m_mdl[i] == 4'h0)
                            sel[i] = (d[7:4] == m_ld[i][7:4]) && ((d[3:0] & m_ld[i][3:0]) != 0);
                    end
                end
                2'd1: sel[i] = m_pres[i] && (i == src);
                2'd2: sel[i] = m_pres[i];
                default: sel[i] = m_pres[i] && (i != src);
            endcase
            if (sel[i] && lowest < 0) lowest = i;
        end
        exp_act = 3'd0;
        case (md)
            3'd0: exp_act = 3'd1;
            3'd1: exp_act = 3'd2;
            3'd2: exp_act = 3'd3;
            3'd4: exp_act = 3'd4;
            3'd5: exp_act = (!lv && tr) ? 3'd7 : 3'd5;
            3'd6: exp_act = 3'd6;
            default: exp_act = 3'd0;
        endcase
        for (int i = 0; i < N; i++) begin
            if (exp_act == 3'd2) exp_mask[i] = (i == lowest);
            else if (exp_act != 3'd0 && exp_act != 3'd7) exp_mask[i] = sel[i];
            if (exp_act == 3'd7 && sel[i]) m_arb[i] = m_id[i];
            if (exp_act == 3'd6 && sel[i]) m_vec[i] = v;
        end

        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_logical = lg; req_short = sh;
        req_mode = md; req_vector = v; req_level = lv; req_trigger = tr;
        req_src = IW'(src);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R11", {rq, " busy after accept"}, 64'(busy), 64'd1);
        for (int k = 2; k <= N + 1; k++) begin
            @(negedge clk);
            if (done !== 1'b0 || busy !== 1'b1) early = 1'b1;
            if (inject && k == 3) begin
                req_valid = 1'b1; req_dest = 8'hFF; req_logical = 1'b0;
                req_short = 2'd2; req_mode = 3'd0; req_vector = 8'hEE;
            end
            if (inject && k == 4) req_valid = 1'b0;
            if (cw && k == N + 1) begin
                cfg_we = 1'b1; cfg_slot = IW'(cw_slot); cfg_present = m_pres[cw_slot];
                cfg_id = cw_id; cfg_ldest = m_ld[cw_slot]; cfg_model = m_mdl[cw_slot];
            end
        end
        chk(!early, "R11", {rq, " done low and busy high during walk"}, 64'(early), 64'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        if (cw) m_id[cw_slot] = cw_id;
        chk(done === 1'b1 && busy === 1'b0, "R11", {rq, " done/busy at completion"},
            {62'd0, done, busy}, 64'd2);
        chk(tgt_mask === exp_mask, rq, "target mask", 64'(tgt_mask), 64'(exp_mask));
        chk(tgt_action === exp_act, rq, "action", 64'(tgt_action), 64'(exp_act));
        chk(tgt_vector === v, rq, "vector", 64'(tgt_vector), 64'(v));
        chk(low_valid === (exp_act == 3'd2 && lowest >= 0), "R8", {rq, " low_valid"},
            64'(low_valid), 64'(exp_act == 3'd2 && lowest >= 0));
        if (exp_act == 3'd2 && lowest >= 0)
            chk(low_slot === IW'(lowest), "R8", {rq, " low_slot"}, 64'(low_slot), 64'(lowest));
        @(negedge clk);
        chk(done === 1'b0, "R11", {rq, " single done pulse"}, 64'(done), 64'd0);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", {rq, " no second result"},
            {62'd0, done, busy}, 64'd0);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_pres[i] = 0; m_id[i] = 0; m_ld[i] = 0; m_mdl[i] = 0; m_arb[i] = 0; m_vec[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(done === 1'b0 && busy === 1'b0, "R12", "done/busy after reset", {62'd0, done, busy}, 64'd0);
        chk(tgt_mask === '0, "R12", "mask after reset", 64'(tgt_mask), 64'd0);
        check_tables("R12");

        // table: flat slots 0..7, cluster 8..13, odd model 14, flat 15, 16..19 empty
        for (int i = 0; i < 8; i++)
            cfg_write(i, 1'b1, 8'(8'h10 + i), 8'(1 << i), 4'hF);
        cfg_write(7, 1'b1, 8'h33, 8'h80, 4'hF);
        for (int i = 8; i < 14; i++)
            cfg_write(i, 1'b1, 8'(8'h10 + i), 8'(((i < 11) ? 8'h10 : 8'h20) | (1 << (i % 4))), 4'h0);
        cfg_write(12, 1'b1, 8'h33, 8'h21, 4'h0);
        cfg_write(14, 1'b1, 8'h1E, 8'hFF, 4'h5);
        cfg_write(15, 1'b1, 8'h1F, 8'h80, 4'hF);
        cfg_write(17, 1'b0, 8'h40, 8'hFF, 4'hF);

        run_req(8'hFF, 0, 2'd0, 3'd0, 8'h41, 0, 0, 0, 0, 0, 0, 0, "R1");
        run_req(8'h33, 0, 2'd0, 3'd4, 8'h42, 0, 0, 0, 0, 0, 0, 0, "R2");
        run_req(8'h40, 0, 2'd0, 3'd2, 8'h43, 0, 0, 0, 0, 0, 0, 0, "R6");
        run_req(8'h05, 1, 2'd0, 3'd0, 8'h44, 0, 0, 0, 0, 0, 0, 0, "R3");
        run_req(8'h13, 1, 2'd0, 3'd5, 8'h45, 1, 0, 0, 0, 0, 0, 0, "R4");
        run_req(8'h2C, 1, 2'd0, 3'd2, 8'h46, 0, 0, 0, 0, 0, 0, 0, "R4");
        run_req(8'h00, 0, 2'd1, 3'd6, 8'h9A, 0, 0, 3, 0, 0, 0, 0, "R5");
        check_tables("R10");
        run_req(8'h00, 0, 2'd3, 3'd6, 8'h5C, 0, 0, 2, 0, 0, 0, 0, "R10");
        check_tables("R10");
        run_req(8'h00, 0, 2'd2, 3'd1, 8'h47, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_req(8'h2C, 1, 2'd0, 3'd1, 8'h48, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_req(8'h77, 0, 2'd0, 3'd1, 8'h49, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_req(8'hFF, 0, 2'd0, 3'd7, 8'h4A, 0, 0, 0, 0, 0, 0, 0, "R7");
        run_req(8'hFF, 0, 2'd2, 3'd3, 8'h4B, 0, 0, 0, 0, 0, 0, 0, "R7");
        run_req(8'hFF, 0, 2'd0, 3'd5, 8'h4C, 1, 1, 0, 0, 0, 0, 0, "R7");
        run_req(8'h00, 0, 2'd2, 3'd5, 8'h4D, 0, 1, 0, 1, 5, 8'h99, 0, "R9");
        check_tables("R9");
        run_req(8'h00, 0, 2'd1, 3'd0, 8'h4E, 0, 0, 18, 0, 0, 0, 0, "R6");
        run_req(8'h33, 0, 2'd0, 3'd0, 8'h4F, 0, 0, 0, 0, 0, 0, 1, "R11");
        run_req(8'h99, 0, 2'd0, 3'd0, 8'h50, 0, 0, 0, 0, 0, 0, 0, "R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule